// File: doc/BRIEF.md
# Sequential Double-Width Integer Divider

This unit divides a dividend of twice the operand width by a single-width divisor and returns a quotient and a remainder. It works at three operand sizes, a byte, a halfword and a word, and treats the operands either as unsigned values or as two's complement values. A caller places the operands and the mode on the inputs and pulses `start`. The unit raises `busy` while it works, then pulses `done` for one cycle with the results on `res_hi` and `res_lo`.

The unit produces one quotient bit per clock on operand magnitudes, using restoring subtraction. It runs over every bit of the double-width dividend, so the complete quotient is known before anything is written. After the last step it corrects the signs and checks whether the quotient fits the destination. A quotient that does not fit, or a zero divisor, raises `fault` together with `done`. In that case the result registers keep their previous contents. The unit drives no arithmetic flags. Fetching the operands, updating the flags and taking the trap are left to the surrounding pipeline.

Top module: `wide_divider`

## Requirements
- R1: With `size_sel` = 2 (word) the dividend is {num_hi, num_lo} and the divisor is `divisor`. On success the remainder appears on `res_hi` and the quotient on `res_lo`. The reserved code `size_sel` = 3 behaves exactly like 2.
- R2: With `size_sel` = 1 (halfword) the dividend is {num_hi[15:0], num_lo[15:0]} and the divisor is divisor[15:0]. The remainder goes to res_hi[15:0] and the quotient to res_lo[15:0], and the upper halves of both outputs are zero.
- R3: With `size_sel` = 0 (byte) the dividend is num_lo[15:0] and the divisor is divisor[7:0]. The result is packed as res_lo[15:8] = remainder and res_lo[7:0] = quotient. All other output bits are zero and `num_hi` has no effect.
- R4: With `signed_mode` = 1 the operands are two's complement at the selected size. The quotient truncates toward zero, the remainder takes the sign of the dividend, and both are returned in two's complement at that size.
- R5: If the quotient does not fit the destination, `fault` is raised with `done` and `res_hi`/`res_lo` keep their previous values. The destination holds 0 to 2^N-1 when unsigned and -2^(N-1) to 2^(N-1)-1 when signed.
- R6: A divisor of zero at the selected size raises `fault` with `done` two cycles after the start edge, and the results are left unchanged.
- R7: A start accepted at rising edge k raises `busy` from edge k. For a nonzero divisor, `done` rises at edge k+2N+1, where N is the operand size, and `busy` is low in the `done` cycle.
- R8: `done` is high for exactly one cycle per accepted operation, and `fault` is high only while `done` is high.
- R9: `start` and all operand inputs are ignored while `busy` is high, and the result outputs do not change while `busy` is high.
- R10: After reset `busy`, `done` and `fault` are low and `res_hi` and `res_lo` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; accepted only when not busy |
| size_sel | input | 2 | Operand size: 0 byte, 1 halfword, 2 or 3 word |
| signed_mode | input | 1 | 1 selects two's complement division |
| num_hi | input | DATA_W | Upper word of the dividend |
| num_lo | input | DATA_W | Lower word of the dividend |
| divisor | input | DATA_W | Divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Overflow or zero divisor, valid with done |
| res_hi | output | DATA_W | Remainder (halfword and word sizes) |
| res_lo | output | DATA_W | Quotient, or packed remainder and quotient for bytes |

## Verification
The bench builds the unit with its default DATA_W of 32. At that width all three operand sizes can be reached, including the 64-bit word dividend and its most negative values such as -2^31 divided by -1. Directed cases cover the exact signed and unsigned overflow boundaries, zero divisors at each size, the reserved size code and operands changed during an operation. The random cases mix all sizes and modes, with dividends kept small in about half of them so that results that fit and results that overflow both occur often.

// File: rtl/wdiv_pkg.sv
package wdiv_pkg;

    // Operand size selector; the reserved code falls back to the word size.
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_FIN  = 2'd2
    } phase_e;

endpackage

// File: rtl/wdiv_prep.sv
// Operand preparation: selects the active slices, sign-extends them,
// converts them to magnitudes and left-aligns the dividend for iteration.
module wdiv_prep
    import wdiv_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  size_e                     size_i,
    input  logic                      sgn_i,
    input  logic [DATA_W-1:0]         hi_i,
    input  logic [DATA_W-1:0]         lo_i,
    input  logic [DATA_W-1:0]         dvs_i,
    output logic [2*DATA_W-1:0]       dend_o,
    output logic [DATA_W-1:0]         dvs_mag_o,
    output logic                      q_neg_o,
    output logic                      r_neg_o,
    output logic                      dvs_zero_o,
    output logic [$clog2(2*DATA_W):0] iters_o
);

    localparam int DW = 2 * DATA_W;
    localparam int NB = DATA_W / 4;
    localparam int NH = DATA_W / 2;
    localparam int CW = $clog2(DW) + 1;

    logic [DW-1:0]     dend_sx;
    logic [DW-1:0]     dend_mag;
    logic [DATA_W-1:0] dvs_sx;
    logic [CW-1:0]     align;
    logic              d_neg;
    logic              v_neg;

    always_comb begin
        case (size_i)
            SZ_BYTE: begin
                dend_sx = {{(DW-2*NB){sgn_i & lo_i[2*NB-1]}}, lo_i[2*NB-1:0]};
                dvs_sx  = {{(DATA_W-NB){sgn_i & dvs_i[NB-1]}}, dvs_i[NB-1:0]};
                align   = CW'(DW - 2*NB);
                iters_o = CW'(2*NB);
            end
            SZ_HALF: begin
                dend_sx = {{(DW-2*NH){sgn_i & hi_i[NH-1]}}, hi_i[NH-1:0], lo_i[NH-1:0]};
                dvs_sx  = {{(DATA_W-NH){sgn_i & dvs_i[NH-1]}}, dvs_i[NH-1:0]};
                align   = CW'(DW - 2*NH);
                iters_o = CW'(2*NH);
            end
            default: begin
                dend_sx = {hi_i, lo_i};
                dvs_sx  = dvs_i;
                align   = '0;
                iters_o = CW'(DW);
            end
        endcase

        d_neg      = sgn_i & dend_sx[DW-1];
        v_neg      = sgn_i & dvs_sx[DATA_W-1];
        dend_mag   = d_neg ? (~dend_sx + 1'b1) : dend_sx;
        dvs_mag_o  = v_neg ? (~dvs_sx + 1'b1) : dvs_sx;
        dend_o     = dend_mag << align;
        q_neg_o    = d_neg ^ v_neg;
        r_neg_o    = d_neg;
        dvs_zero_o = (dvs_sx == '0);
    end

endmodule

// File: rtl/wdiv_step.sv
// One restoring division step: shifts in the next dividend bit and
// subtracts the divisor when the partial remainder allows it.
module wdiv_step #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]   rem_i,
    input  logic [2*DATA_W-1:0] quo_i,
    input  logic [DATA_W-1:0]   dvs_i,
    output logic [DATA_W-1:0]   rem_o,
    output logic [2*DATA_W-1:0] quo_o
);

    localparam int DW = 2 * DATA_W;

    logic [DATA_W:0] trial;
    logic [DATA_W:0] diff;

    always_comb begin
        trial = {rem_i, quo_i[DW-1]};
        diff  = trial - {1'b0, dvs_i};
        if (diff[DATA_W]) begin
            rem_o = trial[DATA_W-1:0];
            quo_o = {quo_i[DW-2:0], 1'b0};
        end else begin
            rem_o = diff[DATA_W-1:0];
            quo_o = {quo_i[DW-2:0], 1'b1};
        end
    end

endmodule

// File: rtl/wdiv_post.sv
// Final stage: overflow test against the destination range, sign
// correction of quotient and remainder, and packing per operand size.
module wdiv_post
    import wdiv_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  size_e               size_i,
    input  logic                sgn_i,
    input  logic                q_neg_i,
    input  logic                r_neg_i,
    input  logic [2*DATA_W-1:0] quo_i,
    input  logic [DATA_W-1:0]   rem_i,
    output logic                ovf_o,
    output logic [DATA_W-1:0]   res_hi_o,
    output logic [DATA_W-1:0]   res_lo_o
);

    localparam int DW = 2 * DATA_W;
    localparam int NB = DATA_W / 4;
    localparam int NH = DATA_W / 2;
    localparam logic [DW-1:0] ONE = DW'(1);

    int                n;
    logic [DW-1:0]     limit;
    logic [DATA_W-1:0] q_s;
    logic [DATA_W-1:0] r_s;

    always_comb begin
        case (size_i)
            SZ_BYTE: n = NB;
            SZ_HALF: n = NH;
            default: n = DATA_W;
        endcase

        limit = (ONE << (n - 1)) - {{(DW-1){1'b0}}, ~q_neg_i};
        if (sgn_i) begin
            ovf_o = (quo_i > limit);
        end else begin
            ovf_o = |(quo_i >> n);
        end

        q_s = q_neg_i ? (~quo_i[DATA_W-1:0] + 1'b1) : quo_i[DATA_W-1:0];
        r_s = r_neg_i ? (~rem_i + 1'b1) : rem_i;

        case (size_i)
            SZ_BYTE: begin
                res_hi_o = '0;
                res_lo_o = {{(DATA_W-2*NB){1'b0}}, r_s[NB-1:0], q_s[NB-1:0]};
            end
            SZ_HALF: begin
                res_hi_o = {{(DATA_W-NH){1'b0}}, r_s[NH-1:0]};
                res_lo_o = {{(DATA_W-NH){1'b0}}, q_s[NH-1:0]};
            end
            default: begin
                res_hi_o = r_s;
                res_lo_o = q_s;
            end
        endcase
    end

endmodule

// File: rtl/wide_divider.sv
// Sequential double-width divider, one quotient bit per clock.
module wide_divider
    import wdiv_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        size_sel,
    input  logic              signed_mode,
    input  logic [DATA_W-1:0] num_hi,
    input  logic [DATA_W-1:0] num_lo,
    input  logic [DATA_W-1:0] divisor,
    output logic              busy,
    output logic              done,
    output logic              fault,
    output logic [DATA_W-1:0] res_hi,
    output logic [DATA_W-1:0] res_lo
);

    localparam int DW = 2 * DATA_W;
    localparam int CW = $clog2(DW) + 1;

    typedef struct packed {
        phase_e            phase;
        logic [CW-1:0]     cnt;
        logic [DATA_W-1:0] rem;
        logic [DW-1:0]     quo;
        logic [DATA_W-1:0] dvs;
        size_e             size;
        logic              sgn;
        logic              q_neg;
        logic              r_neg;
        logic              zdiv;
        logic [DATA_W-1:0] res_hi;
        logic [DATA_W-1:0] res_lo;
        logic              done;
        logic              fault;
    } state_t;

    state_t s_d, s_q;

    logic [DW-1:0]     prep_dend;
    logic [DATA_W-1:0] prep_dvs;
    logic              prep_qneg;
    logic              prep_rneg;
    logic              prep_zero;
    logic [CW-1:0]     prep_iters;
    logic [DATA_W-1:0] step_rem;
    logic [DW-1:0]     step_quo;
    logic              post_ovf;
    logic [DATA_W-1:0] post_hi;
    logic [DATA_W-1:0] post_lo;

    wdiv_prep #(.DATA_W(DATA_W)) u_prep (
        .size_i     (size_e'(size_sel)),
        .sgn_i      (signed_mode),
        .hi_i       (num_hi),
        .lo_i       (num_lo),
        .dvs_i      (divisor),
        .dend_o     (prep_dend),
        .dvs_mag_o  (prep_dvs),
        .q_neg_o    (prep_qneg),
        .r_neg_o    (prep_rneg),
        .dvs_zero_o (prep_zero),
        .iters_o    (prep_iters)
    );

    wdiv_step #(.DATA_W(DATA_W)) u_step (
        .rem_i (s_q.rem),
        .quo_i (s_q.quo),
        .dvs_i (s_q.dvs),
        .rem_o (step_rem),
        .quo_o (step_quo)
    );

    wdiv_post #(.DATA_W(DATA_W)) u_post (
        .size_i   (s_q.size),
        .sgn_i    (s_q.sgn),
        .q_neg_i  (s_q.q_neg),
        .r_neg_i  (s_q.r_neg),
        .quo_i    (s_q.quo),
        .rem_i    (s_q.rem),
        .ovf_o    (post_ovf),
        .res_hi_o (post_hi),
        .res_lo_o (post_lo)
    );

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        s_d.fault = 1'b0;
        case (s_q.phase)
            PH_IDLE: begin
                if (start) begin
                    s_d.size  = size_e'(size_sel);
                    s_d.sgn   = signed_mode;
                    s_d.rem   = '0;
                    s_d.quo   = prep_dend;
                    s_d.dvs   = prep_dvs;
                    s_d.q_neg = prep_qneg;
                    s_d.r_neg = prep_rneg;
                    s_d.zdiv  = prep_zero;
                    s_d.cnt   = prep_iters;
                    s_d.phase = prep_zero ? PH_FIN : PH_RUN;
                end
            end
            PH_RUN: begin
                s_d.rem = step_rem;
                s_d.quo = step_quo;
                s_d.cnt = s_q.cnt - 1'b1;
                if (s_q.cnt == CW'(1)) begin
                    s_d.phase = PH_FIN;
                end
            end
            PH_FIN: begin
                s_d.phase = PH_IDLE;
                s_d.done  = 1'b1;
                if (s_q.zdiv || post_ovf) begin
                    s_d.fault = 1'b1;
                end else begin
                    s_d.res_hi = post_hi;
                    s_d.res_lo = post_lo;
                end
            end
            default: begin
                s_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy   = (s_q.phase != PH_IDLE);
    assign done   = s_q.done;
    assign fault  = s_q.fault;
    assign res_hi = s_q.res_hi;
    assign res_lo = s_q.res_lo;

endmodule

// File: rtl/wdiv_checker.sv
// Temporal properties of the divider, attached through bind.
module wdiv_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [1:0]        size_sel,
    input logic [DATA_W-1:0] divisor,
    input logic              busy,
    input logic              done,
    input logic              fault,
    input logic [DATA_W-1:0] res_hi,
    input logic [DATA_W-1:0] res_lo
);

    logic last_byte;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_byte <= 1'b0;
        end else if (start && !busy) begin
            last_byte <= (size_sel == 2'd0);
        end
    end

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_fault_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> done);

    assert_idle_when_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_hold_on_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> ($stable(res_hi) && $stable(res_lo)));

    assert_hold_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($stable(res_hi) && $stable(res_lo)));

    assert_busy_until_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));

    assert_zero_divisor_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && size_sel == 2'd2 && divisor == '0) |-> ##2 (done && fault));

    assert_byte_hi_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault && last_byte) |-> (res_hi == '0));

endmodule

bind wide_divider wdiv_checker #(.DATA_W(DATA_W)) u_wdiv_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .size_sel (size_sel),
    .divisor  (divisor),
    .busy     (busy),
    .done     (done),
    .fault    (fault),
    .res_hi   (res_hi),
    .res_lo   (res_lo)
);

// File: tb/tb_wide_divider.sv
`timescale 1ns/1ps
module tb_wide_divider;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   size_sel = 2'd0;
    logic         signed_mode = 1'b0;
    logic [W-1:0] num_hi = '0;
    logic [W-1:0] num_lo = '0;
    logic [W-1:0] divisor = '0;
    logic         busy, done, fault;
    logic [W-1:0] res_hi, res_lo;

    int checks = 0;
    int fails = 0;
    logic [W-1:0] keep_hi = '0;
    logic [W-1:0] keep_lo = '0;

    always #4 clk = ~clk;

    wide_divider #(.DATA_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .size_sel(size_sel),
        .signed_mode(signed_mode), .num_hi(num_hi), .num_lo(num_lo),
        .divisor(divisor), .busy(busy), .done(done), .fault(fault),
        .res_hi(res_hi), .res_lo(res_lo)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected outcome from the requirements, computed on 64-bit magnitudes.
    function automatic void model(input logic [1:0] sz, input bit s,
                                  input logic [31:0] hi, input logic [31:0] lo,
                                  input logic [31:0] dv,
                                  output logic [31:0] eh, output logic [31:0] el,
                                  output bit ef, output bit ez, output int lat);
        int n;
        bit [63:0] dend, dvv, dsx, vsx, dm, vm, q, r, lim, qs, rs;
        bit dn, vn, qn, ovf;
        n = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        case (sz)
            2'd0:    dend = {48'b0, lo[15:0]};
            2'd1:    dend = {32'b0, hi[15:0], lo[15:0]};
            default: dend = {hi, lo};
        endcase
        dvv = {32'b0, dv} & ((64'd1 << n) - 64'd1);
        dn  = s && dend[2*n-1];
        vn  = s && dvv[n-1];
        dsx = dn ? (dend | (~64'd0 << (2*n))) : dend;
        vsx = vn ? (dvv | (~64'd0 << n)) : dvv;
        dm  = dn ? -dsx : dsx;
        vm  = vn ? -vsx : vsx;
        eh = keep_hi;
        el = keep_lo;
        ez = 1'b0;
        if (vm == 64'd0) begin
            ef  = 1'b1;
            ez  = 1'b1;
            lat = 2;
            return;
        end
        lat = 2*n + 2;
        q  = dm / vm;
        r  = dm % vm;
        qn = dn ^ vn;
        if (s) begin
            lim = (64'd1 << (n-1)) - (qn ? 64'd0 : 64'd1);
            ovf = (q > lim);
        end else begin
            ovf = ((q >> n) != 64'd0);
        end
        ef = ovf;
        if (ovf) return;
        qs = qn ? -q : q;
        rs = dn ? -r : r;
        case (sz)
            2'd0: begin
                eh = '0;
                el = {16'b0, rs[7:0], qs[7:0]};
            end
            2'd1: begin
                eh = {16'b0, rs[15:0]};
                el = {16'b0, qs[15:0]};
            end
            default: begin
                eh = rs[31:0];
                el = qs[31:0];
            end
        endcase
    endfunction

    task automatic run_op(input logic [1:0] sz, input bit s, input logic [31:0] hi,
                          input logic [31:0] lo, input logic [31:0] dv,
                          input bit disturb);
        logic [31:0] eh, el;
        bit ef, ez;
        int lat, seen;
        string tag, ftag;
        model(sz, s, hi, lo, dv, eh, el, ef, ez, lat);
        if (disturb)           tag = "R9";
        else if (s)            tag = "R4";
        else if (sz == 2'd0)   tag = "R3";
        else if (sz == 2'd1)   tag = "R2";
        else                   tag = "R1";
        ftag = ef ? (ez ? "R6" : "R5") : tag;
        @(negedge clk);
        size_sel = sz; signed_mode = s; num_hi = hi; num_lo = lo; divisor = dv;
        start = 1'b1;
        seen = 0;
        for (int j = 1; j <= 200; j++) begin
            @(negedge clk);
            if (disturb) begin
                start = 1'b1;
                size_sel = 2'($urandom);
                signed_mode = 1'($urandom);
                num_hi = $urandom; num_lo = $urandom; divisor = $urandom;
            end else begin
                start = 1'b0;
            end
            if (j > 1 && !done) check(busy, "R7", "busy during run", 64'(busy), 64'd1);
            if (done) begin
                seen = j;
                break;
            end
        end
        start = 1'b0;
        check(seen == lat, "R7", "latency", 64'(seen), 64'(lat));
        check(fault == ef, ftag, "fault", 64'(fault), 64'(ef));
        check(res_hi == eh, ftag, "res_hi", 64'(res_hi), 64'(eh));
        check(res_lo == el, ftag, "res_lo", 64'(res_lo), 64'(el));
        keep_hi = res_hi;
        keep_lo = res_lo;
        @(negedge clk);
        check(!done && !fault, "R8", "done/fault after pulse", {62'b0, done, fault}, 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R7 watchdog actual=hung expected=completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [1:0] sz;
        bit s;
        logic [31:0] hi, lo, dv;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check(!busy && !done && !fault, "R10", "flags in reset",
              {61'b0, busy, done, fault}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !fault, "R10", "flags after reset",
              {61'b0, busy, done, fault}, 64'd0);
        check(res_hi == '0 && res_lo == '0, "R10", "results after reset",
              {res_hi, res_lo}, 64'd0);

        // Directed corners
        run_op(2'd2, 1'b0, 32'h1, 32'h0, 32'h10, 1'b0);                     // R1
        run_op(2'd2, 1'b0, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0); // R1 max fit
        run_op(2'd2, 1'b0, 32'h5, 32'h0, 32'h5, 1'b0);                     // R5 unsigned
        run_op(2'd2, 1'b0, 32'h1234, 32'h5678, 32'h0, 1'b0);               // R6 word
        run_op(2'd0, 1'b1, 32'h0, 32'h0042, 32'hFFFF_FF00, 1'b0);           // R6 byte slice zero
        run_op(2'd1, 1'b0, 32'hABCD_0001, 32'h5555_0000, 32'h7777_0003, 1'b0); // R2
        run_op(2'd0, 1'b0, 32'h0, 32'h0000_1000, 32'h10, 1'b0);             // R5 byte
        run_op(2'd0, 1'b0, 32'hDEAD_BEEF, 32'hCAFE_00FF, 32'h10, 1'b0);     // R3 hi ignored
        run_op(2'd0, 1'b1, 32'h0, 32'h0000_FF80, 32'h0000_00FF, 1'b0);      // R5 -128/-1
        run_op(2'd0, 1'b1, 32'h0, 32'h0000_FF80, 32'h0000_0001, 1'b0);      // R4 -128/1
        run_op(2'd1, 1'b1, 32'hFFFF, 32'hFFF9, 32'h2, 1'b0);                // R4 -7/2
        run_op(2'd2, 1'b1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h1, 1'b0);      // R4 min/1
        run_op(2'd2, 1'b1, 32'hFFFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0); // R5 min/-1
        run_op(2'd2, 1'b1, 32'h0, 32'h7, 32'hFFFF_FFFE, 1'b0);              // R4 7/-2
        run_op(2'd3, 1'b0, 32'h2, 32'h3, 32'h9, 1'b0);                      // R1 reserved code
        run_op(2'd2, 1'b0, 32'h0, 32'd1000, 32'd7, 1'b1);                   // R9 disturb
        run_op(2'd0, 1'b1, 32'h0, 32'h0000_0123, 32'h0000_00F9, 1'b1);      // R9 disturb byte

        // Constrained random
        for (int i = 0; i < 300; i++) begin
            sz = 2'($urandom);
            s  = 1'($urandom);
            hi = $urandom;
            lo = $urandom;
            dv = ($urandom % 16 == 0) ? 32'h0 : $urandom;
            if ($urandom % 4 == 0) dv = dv & 32'hFF;
            if ($urandom % 2 == 0) begin
                hi = (dv == 0) ? 32'h0 : (hi % (dv >> 1 | 32'h1));
                lo = (sz == 2'd0) ? {16'h0, 8'h0, lo[7:0]} : lo;
            end
            run_op(sz, s, hi, lo, dv, 1'b0);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule